// File: doc/BRIEF.md
# Register Burst Address Limiter

This block sits in front of a bank of memory-mapped registers whose address space is 31 bits wide. A caller asks for a burst of register accesses by giving a byte start address and a count of registers. The block works out how many of those registers actually exist between the start address and the topmost register at 0x7FFFFFFC. It grants that many, and rejects start addresses that fall outside the space or are not word aligned.

Once a burst is accepted, the block walks the granted registers one per clock. It presents each register address with a valid strobe and raises a one-cycle completion pulse after the last one. A separate combinational data path clears the unused top bit of register read data, because only 31 bits of each register are real.

Top module: `burst_lim_top`

## Requirements
- R1: After reset, `addr_valid_o`, `done_o` and `err_o` are 0 and `grant_len_o` is 0.
- R2: For a word-aligned start address with bit 31 clear, a request that fits below 0x7FFFFFFC is granted in full (`grant_len_o` equals `req_len_i`, `err_o` = 0).
- R3: For a valid start address, the grant is the smaller of the request and ((0x7FFFFFFC - start) / 4) + 1. For example, start 0x7FFFFFF8 with a request of 5 grants 2. No emitted address ever exceeds 0x7FFFFFFC.
- R4: A start address with bit 31 set gives `err_o` = 1 and a grant of 0, and no address is emitted.
- R5: A start address with either of bits 1:0 set gives `err_o` = 1 and a grant of 0, and no address is emitted.
- R6: After an accepted start, `addr_valid_o` is high for exactly the granted number of consecutive cycles, beginning the cycle after the start is sampled. `addr_o` takes the values start, start+4, start+8, and so on.
- R7: `done_o` is high for exactly one cycle, immediately after the last valid address, or the cycle after the start when the grant is 0.
- R8: A requested length of 0 grants 0 with `err_o` = 0, and `done_o` follows on the next cycle.
- R9: A start pulse that arrives while a burst is in progress is ignored: the address stream, grant and error flag are unchanged.
- R10: `rd_data_o` equals `rd_data_i` with bit 31 forced to 0.
- R11: `grant_len_o` and `err_o` are captured when a start is accepted and hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request pulse; sampled only when idle |
| start_addr_i | input | 32 | Byte address of the first register |
| req_len_i | input | 8 | Requested number of registers |
| rd_data_i | input | 32 | Raw register read data |
| grant_len_o | output | 8 | Granted number of registers for the last accepted request |
| err_o | output | 1 | Last accepted request had an invalid start address |
| addr_o | output | 32 | Current register address of the burst |
| addr_valid_o | output | 1 | `addr_o` holds a granted address this cycle |
| done_o | output | 1 | One-cycle pulse when the burst is finished |
| rd_data_o | output | 32 | Read data with the invalid top bit cleared |

## Verification
The assertions assume that start address and length are stable in the cycle that `start_i` is sampled. They also assume the requested length fits the 8-bit port, so the clamped grant cannot overflow the grant register. The bench drives all request fields together with the start pulse at the falling edge and releases the pulse one cycle later. It pushes the addresses it expects, then a completion marker, into a scoreboard queue that a monitor drains at each falling edge. The only stimulus given during a burst is a deliberately ignored start pulse; it asserts an out-of-range address to show that nothing is latched.

// File: rtl/burst_lim_pkg.sv
// Package: shared types for the register burst address limiter.
// Assumes nothing beyond being compiled before the modules that import it.
package burst_lim_pkg;

    // Burst sequencer states: waiting, walking addresses, signalling completion.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/burst_lim_grant.sv
// Module: burst_lim_grant
// Combinational grant calculation. Flags a start address that is outside the
// 31-bit space or not word aligned, and clamps the requested register count to
// the registers that remain up to and including TOP_ADDR.
// Assumes ADDR_W >= LEN_W and ALIGN_B >= 1.
module burst_lim_grant #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned LEN_W   = 8,
    parameter int unsigned ALIGN_B = 2,
    parameter logic [ADDR_W-1:0] TOP_ADDR = 32'h7FFF_FFFC
) (
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [LEN_W-1:0]  req_len_i,
    output logic [LEN_W-1:0]  grant_len_o,
    output logic              bad_o
);

    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] room;
    logic [ADDR_W-1:0] req_ext;

    // Purpose: validate the start address and pick min(request, room left).
    always_comb begin
        bad_o   = start_addr_i[ADDR_W-1] | (|start_addr_i[ALIGN_B-1:0]);
        span    = TOP_ADDR - start_addr_i;
        room    = (span >> ALIGN_B) + {{(ADDR_W-1){1'b0}}, 1'b1};
        req_ext = ADDR_W'(req_len_i);
        if (bad_o) begin
            grant_len_o = '0;
        end else if (req_ext < room) begin
            grant_len_o = req_len_i;
        end else begin
            grant_len_o = room[LEN_W-1:0];
        end
    end

endmodule

// File: rtl/burst_lim_seq.sv
// Module: burst_lim_seq
// Burst sequencer. Accepts a start only when idle, captures the grant and
// error flag, then emits one register address per cycle for the granted count
// and pulses done for one cycle afterwards.
// Assumes grant_len_i is already clamped so that no address passes TOP_ADDR.
module burst_lim_seq
    import burst_lim_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned LEN_W   = 8,
    parameter int unsigned ALIGN_B = 2,
    parameter logic [ADDR_W-1:0] TOP_ADDR = 32'h7FFF_FFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [LEN_W-1:0]  grant_len_i,
    input  logic              bad_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_valid_o,
    output logic              done_o,
    output logic [LEN_W-1:0]  grant_q_o,
    output logic              err_q_o
);

    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(1) << ALIGN_B;
    localparam logic [LEN_W-1:0]  ONE    = LEN_W'(1);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  left_q;
    logic [LEN_W-1:0]  grant_q;
    logic              err_q;
    logic              accept;

    assign accept       = (state_q == ST_IDLE) && start_i;
    assign addr_o       = addr_q;
    assign addr_valid_o = (state_q == ST_RUN);
    assign done_o       = (state_q == ST_DONE);
    assign grant_q_o    = grant_q;
    assign err_q_o      = err_q;

    // Purpose: state, address walk, remaining count and captured grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            left_q  <= '0;
            grant_q <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        grant_q <= grant_len_i;
                        err_q   <= bad_i;
                        addr_q  <= base_addr_i;
                        left_q  <= grant_len_i;
                        state_q <= (grant_len_i == '0) ? ST_DONE : ST_RUN;
                    end
                end
                ST_RUN: begin
                    addr_q <= addr_q + STRIDE;
                    left_q <= left_q - ONE;
                    if (left_q == ONE) begin
                        state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Checker state: beats emitted since the last accepted start.
    logic [LEN_W-1:0] beats_q;

    // Purpose: count valid address beats for the completion check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats_q <= '0;
        end else if (accept) begin
            beats_q <= '0;
        end else if (addr_valid_o) begin
            beats_q <= beats_q + ONE;
        end
    end

    // R6: consecutive beats step by one register.
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && left_q != ONE) |=> (addr_valid_o && addr_o == $past(addr_o) + STRIDE));

    // R6: beat count at completion equals the captured grant.
    assert_beats_match_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (beats_q == grant_q));

    // R7: done follows the last beat directly.
    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && left_q == ONE) |=> done_o);

    // R7: done lasts a single cycle.
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: no emitted address passes the top register or is misaligned.
    assert_addr_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o |-> (addr_o <= TOP_ADDR && addr_o[ALIGN_B-1:0] == '0));

    // R4: a rejected request produces no beats.
    assert_err_no_beats_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !addr_valid_o);

    // R9: captured grant and error stay put while a burst is in flight.
    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(grant_q) && $stable(err_q)));

endmodule

// File: rtl/burst_lim_mask.sv
// Module: burst_lim_mask
// Clears the top data bit, which does not exist in the 31-bit registers.
// Assumes DATA_W >= 2.
module burst_lim_mask #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);

    localparam logic [DATA_W-1:0] KEEP = {1'b0, {(DATA_W-1){1'b1}}};

    // Purpose: keep only the valid low bits.
    always_comb begin
        data_o = data_i & KEEP;
    end

endmodule

// File: rtl/burst_lim_top.sv
// Module: burst_lim_top
// Register burst address limiter: validates and clamps a register burst
// against the 31-bit address space, walks the granted addresses, and masks
// read data to its valid bits.
// Assumes start_addr_i and req_len_i are valid in the cycle start_i is high.
module burst_lim_top #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [LEN_W-1:0]  req_len_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [LEN_W-1:0]  grant_len_o,
    output logic              err_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_valid_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int unsigned ALIGN_B = $clog2(DATA_W / 8);
    localparam logic [ADDR_W-1:0] TOP_ADDR =
        {1'b0, {(ADDR_W-1-ALIGN_B){1'b1}}, {ALIGN_B{1'b0}}};

    logic [LEN_W-1:0] grant_comb;
    logic             bad_comb;

    burst_lim_grant #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ALIGN_B(ALIGN_B), .TOP_ADDR(TOP_ADDR)
    ) grant_i (
        .start_addr_i(start_addr_i),
        .req_len_i   (req_len_i),
        .grant_len_o (grant_comb),
        .bad_o       (bad_comb)
    );

    burst_lim_seq #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ALIGN_B(ALIGN_B), .TOP_ADDR(TOP_ADDR)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .base_addr_i (start_addr_i),
        .grant_len_i (grant_comb),
        .bad_i       (bad_comb),
        .addr_o      (addr_o),
        .addr_valid_o(addr_valid_o),
        .done_o      (done_o),
        .grant_q_o   (grant_len_o),
        .err_q_o     (err_o)
    );

    burst_lim_mask #(.DATA_W(DATA_W)) mask_i (
        .data_i(rd_data_i),
        .data_o(rd_data_o)
    );

    // R5: a flagged request always carries a zero grant.
    assert_err_zero_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (grant_len_o == '0));

    // R8: a zero grant finishes on the very next cycle.
    assert_zero_grant_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !addr_valid_o && !done_o && !$past(addr_valid_o) && grant_comb == '0
         && $past(rst_n)) |=> done_o);

endmodule

// File: tb/burst_lim_top_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected addresses plus a done marker;
// the monitor drains the queue on each falling edge.
module burst_lim_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic [7:0]  req_len_i = '0;
    logic [31:0] rd_data_i = '0;
    logic [7:0]  grant_len_o;
    logic        err_o;
    logic [31:0] addr_o;
    logic        addr_valid_o;
    logic        done_o;
    logic [31:0] rd_data_o;

    int errors = 0;
    int checks = 0;
    logic [32:0] sb_q[$];

    always #10 clk = ~clk;

    burst_lim_top dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .req_len_i(req_len_i), .rd_data_i(rd_data_i), .grant_len_o(grant_len_o),
        .err_o(err_o), .addr_o(addr_o), .addr_valid_o(addr_valid_o),
        .done_o(done_o), .rd_data_o(rd_data_o)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_grant(input logic [31:0] a, input logic [7:0] len);
        longint room;
        if (a[31] || a[1:0] != 2'b00) return 0;
        room = (64'h7FFF_FFFC - longint'({32'b0, a})) / 4 + 1;
        return (longint'(len) < room) ? int'(len) : int'(room);
    endfunction

    // Monitor: each beat or done pulse must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n && (addr_valid_o || done_o)) begin
            if (addr_valid_o && done_o) begin
                chk("R7 done overlaps a beat", 1, 0);
            end else if (sb_q.size() == 0) begin
                chk("R6 unexpected output", {31'b0, addr_valid_o, done_o}, 0);
            end else begin
                logic [32:0] item;
                item = sb_q.pop_front();
                if (item[32]) begin
                    chk("R7 done expected here", {63'b0, done_o}, 1);
                end else begin
                    chk("R6 beat valid", {63'b0, addr_valid_o}, 1);
                    chk("R6 beat address", {32'b0, addr_o}, {32'b0, item[31:0]});
                end
            end
        end
    end

    task automatic run(input string tag, input logic [31:0] a, input logic [7:0] len,
                       input bit poke);
        int g;
        int n;
        bit e;
        e = a[31] || (a[1:0] != 2'b00);
        g = exp_grant(a, len);
        for (int i = 0; i < g; i++) sb_q.push_back({1'b0, a + 32'(4 * i)});
        sb_q.push_back({1'b1, 32'h0});
        @(negedge clk);
        start_i = 1'b1; start_addr_i = a; req_len_i = len;
        @(negedge clk);
        start_i = 1'b0;
        chk({tag, " grant"}, grant_len_o, g);
        chk({tag, " err"}, err_o, e);
        n = 1;
        while (!done_o && n < 400) begin
            start_i = poke && (n == 2);
            if (start_i) begin
                start_addr_i = 32'h8000_0000; req_len_i = 8'd3;
            end
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        chk({tag, " R7 done latency"}, n, g + 1);
        if (poke) begin
            chk("R9 grant held", grant_len_o, g);
            chk("R9 err held", err_o, 0);
        end
        chk({tag, " R11 grant held after done"}, grant_len_o, g);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 addr_valid", addr_valid_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 err", err_o, 0);
        chk("R1 grant", grant_len_o, 0);

        rd_data_i = 32'hFFFF_FFFF; #1 chk("R10 mask all ones", rd_data_o, 32'h7FFF_FFFF);
        rd_data_i = 32'h8000_0001; #1 chk("R10 mask top bit", rd_data_o, 32'h0000_0001);
        rd_data_i = 32'h1234_5678; #1 chk("R10 pass low bits", rd_data_o, 32'h1234_5678);

        run("R2 small", 32'h0000_1000, 8'd5, 1'b0);
        run("R2 long", 32'h0000_0000, 8'd255, 1'b0);
        run("R3 top pair", 32'h7FFF_FFF8, 8'd5, 1'b0);
        run("R3 last reg", 32'h7FFF_FFFC, 8'd3, 1'b0);
        run("R3 clamp 64", 32'h7FFF_FF00, 8'd100, 1'b0);
        run("R3 exact fit", 32'h7FFF_FF00, 8'd64, 1'b0);
        run("R4 bit31", 32'h8000_0000, 8'd4, 1'b0);
        run("R4 high end", 32'hFFFF_FFFC, 8'd1, 1'b0);
        run("R5 misaligned", 32'h0000_0102, 8'd4, 1'b0);
        run("R5 near top", 32'h7FFF_FFFD, 8'd1, 1'b0);
        run("R8 zero len", 32'h0000_0200, 8'd0, 1'b0);
        run("R9 busy start", 32'h0000_0100, 8'd6, 1'b1);
        run("R11 after err", 32'h0000_0040, 8'd2, 1'b0);

        repeat (2) @(negedge clk);
        chk("R6 scoreboard drained", sb_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule